// File: doc/BRIEF.md
# Sector Relocation Slot Unit

This unit sits in the sector address path between a storage host and the card behind it. Every sector the host reads or writes is compared, in the same cycle, against a small set of programmable relocation slots. Each slot has a start sector, a length and a base sector. An access that falls inside a slot is redirected to the matching sector of the relocated region. Any other access passes through unchanged. Slot 0 is used to cover the visible file allocation table with a hidden replacement copy. The other three slots overlay up to three folders with private copies.

The same lookup also labels each sector as ciphertext or plaintext, using a configured sector window. If that window is not valid, every sector is treated as ciphertext. A write that lands in an active slot raises a sticky interrupt and records the slot number. Firmware can then mark that copy as modified, and clears the interrupt with a register write. All setup goes through a simple register write port.

Top module: `sector_remap_unit`

## Requirements
- R1: When start ≤ sector < start + length for a slot that is chosen, `xlat_sector` equals base + (sector − start), modulo 2^32, in the same cycle as the request.
- R2: A sector that lies in no active slot appears on `xlat_sector` unchanged. A slot whose length is zero is inactive and never matches, and a write to it raises no interrupt.
- R3: When several active slots contain the sector, the slot with the lowest index decides the translation and the reported interrupt slot.
- R4: When the cipher window is valid (low < high), `xlat_encrypt` is 1 for low ≤ sector < high and 0 outside it.
- R5: When the cipher window is invalid (low ≥ high), `xlat_encrypt` is 1 for every sector. This includes the state just after reset, where both bounds are zero.
- R6: A valid write request whose sector hits an active slot sets `irq` on the next clock edge, with `irq_slot` holding the index of the winning slot.
- R7: A read request never raises `irq`, even when it hits a slot and is relocated.
- R8: Once `irq` is set, it and `irq_slot` hold their values through later write hits. A write of any data to register address 14 clears `irq` on the next edge, provided no write hit comes in the same cycle. If one does, that hit's slot is latched instead.
- R9: Register map on `cfg_addr`: slot i start at 3·i, slot i length at 3·i+1, slot i base at 3·i+2 (i = 0..3). Cipher window low is at 12 and high (exclusive) is at 13; the interrupt clear is at 14. Reset zeroes every register and clears `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_sector | input | 32 | Sector requested by the host |
| xlat_sector | output | 32 | Sector to use on the card side (combinational) |
| xlat_encrypt | output | 1 | Sector is ciphertext (combinational) |
| irq | output | 1 | Sticky slot write-hit interrupt |
| irq_slot | output | 2 | Index of the slot that raised the interrupt |

## Verification
The assertions take for granted that request and register inputs are stable around the rising edge. They also assume a relocated sector differs from the requested one whenever a write hit is inferred from the ports, so slot bases in the test never map a sector onto itself. The stimulus changes inputs only on the falling edge. It chooses slot bases far from their start sectors. It holds requests for exactly one edge, so each interrupt event is tied to a single known access.

// File: rtl/sremap_pkg.sv
package sremap_pkg;

    parameter int unsigned SECTOR_BITS = 32;
    parameter int unsigned NUM_SLOTS   = 4;

    localparam int unsigned FIELDS_PER_SLOT = 3;
    localparam int unsigned CFG_REG_COUNT   = FIELDS_PER_SLOT * NUM_SLOTS + 3;
    localparam int unsigned CFG_ADDR_BITS   = $clog2(CFG_REG_COUNT);
    localparam int unsigned SLOT_IDX_BITS   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef logic [SECTOR_BITS-1:0]   sector_t;
    typedef logic [CFG_ADDR_BITS-1:0] cfg_addr_t;
    typedef logic [SLOT_IDX_BITS-1:0] slot_idx_t;
    typedef logic [NUM_SLOTS-1:0]     slot_mask_t;

    localparam cfg_addr_t WIN_LO_ADDR  = cfg_addr_t'(FIELDS_PER_SLOT * NUM_SLOTS);
    localparam cfg_addr_t WIN_HI_ADDR  = cfg_addr_t'(FIELDS_PER_SLOT * NUM_SLOTS + 1);
    localparam cfg_addr_t IRQ_CLR_ADDR = cfg_addr_t'(FIELDS_PER_SLOT * NUM_SLOTS + 2);

    typedef struct packed {
        sector_t first;
        sector_t span;
        sector_t target;
    } slot_cfg_t;

    // True when the sector sits inside [first, first + span); overflow-safe.
    function automatic logic in_window(sector_t sector, sector_t first, sector_t span);
        sector_t delta;
        delta = sector - first;
        return (sector >= first) && (delta < span);
    endfunction

    // Cipher window classification; an empty or inverted window means "all".
    function automatic logic is_cipher(sector_t sector, sector_t lo, sector_t hi);
        if (lo >= hi) return 1'b1;
        return (sector >= lo) && (sector < hi);
    endfunction

endpackage

// File: rtl/sremap_cfg_regs.sv
module sremap_cfg_regs
    import sremap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_we,
    input  cfg_addr_t cfg_addr,
    input  sector_t   cfg_wdata,
    output slot_cfg_t slots [NUM_SLOTS],
    output sector_t   win_lo,
    output sector_t   win_hi,
    output logic      irq_clear
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                slots[i] <= '0;
            end
            win_lo <= '0;
            win_hi <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (cfg_addr == cfg_addr_t'(FIELDS_PER_SLOT * i))
                    slots[i].first <= cfg_wdata;
                if (cfg_addr == cfg_addr_t'(FIELDS_PER_SLOT * i + 1))
                    slots[i].span <= cfg_wdata;
                if (cfg_addr == cfg_addr_t'(FIELDS_PER_SLOT * i + 2))
                    slots[i].target <= cfg_wdata;
            end
            if (cfg_addr == WIN_LO_ADDR) win_lo <= cfg_wdata;
            if (cfg_addr == WIN_HI_ADDR) win_hi <= cfg_wdata;
        end
    end

    assign irq_clear = cfg_we && (cfg_addr == IRQ_CLR_ADDR);

endmodule

// File: rtl/sremap_slot_match.sv
module sremap_slot_match
    import sremap_pkg::*;
(
    input  slot_cfg_t cfg,
    input  sector_t   sector,
    output logic      hit,
    output sector_t   moved
);

    sector_t offset;

    always_comb begin
        offset = sector - cfg.first;
        hit    = (cfg.span != '0) && in_window(sector, cfg.first, cfg.span);
        moved  = cfg.target + offset;
    end

endmodule

// File: rtl/sremap_pick.sv
module sremap_pick
    import sremap_pkg::*;
(
    input  slot_mask_t hits,
    input  sector_t    moved [NUM_SLOTS],
    input  sector_t    sector,
    output logic       any_hit,
    output slot_idx_t  winner,
    output sector_t    out_sector
);

    // Scan from the top so the lowest matching index is written last.
    always_comb begin
        winner = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hits[i]) winner = slot_idx_t'(i);
        end
        any_hit    = |hits;
        out_sector = any_hit ? moved[winner] : sector;
    end

endmodule

// File: rtl/sremap_irq_ctrl.sv
module sremap_irq_ctrl
    import sremap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hit_event,
    input  slot_idx_t hit_slot,
    input  logic      clear,
    output logic      irq,
    output slot_idx_t irq_slot
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq      <= 1'b0;
            irq_slot <= '0;
        end else if (clear) begin
            irq <= hit_event;
            if (hit_event) irq_slot <= hit_slot;
        end else if (hit_event && !irq) begin
            irq      <= 1'b1;
            irq_slot <= hit_slot;
        end
    end

endmodule

// File: rtl/sector_remap_unit.sv
module sector_remap_unit
    import sremap_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [CFG_ADDR_BITS-1:0]   cfg_addr,
    input  logic [SECTOR_BITS-1:0]     cfg_wdata,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [SECTOR_BITS-1:0]     req_sector,
    output logic [SECTOR_BITS-1:0]     xlat_sector,
    output logic                       xlat_encrypt,
    output logic                       irq,
    output logic [SLOT_IDX_BITS-1:0]   irq_slot
);

    slot_cfg_t  slot_cfg [NUM_SLOTS];
    sector_t    win_lo;
    sector_t    win_hi;
    logic       irq_clear;
    slot_mask_t slot_hit;
    sector_t    slot_moved [NUM_SLOTS];
    logic       any_hit;
    slot_idx_t  winner;

    sremap_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .slots     (slot_cfg),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .irq_clear (irq_clear)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        sremap_slot_match u_match (
            .cfg    (slot_cfg[g]),
            .sector (req_sector),
            .hit    (slot_hit[g]),
            .moved  (slot_moved[g])
        );
    end

    sremap_pick u_pick (
        .hits       (slot_hit),
        .moved      (slot_moved),
        .sector     (req_sector),
        .any_hit    (any_hit),
        .winner     (winner),
        .out_sector (xlat_sector)
    );

    assign xlat_encrypt = is_cipher(req_sector, win_lo, win_hi);

    sremap_irq_ctrl u_irq (
        .clk       (clk),
        .rst       (rst),
        .hit_event (req_valid && req_write && any_hit),
        .hit_slot  (winner),
        .clear     (irq_clear),
        .irq       (irq),
        .irq_slot  (irq_slot)
    );

endmodule

// File: rtl/sremap_checker.sv
module sremap_checker
    import sremap_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      cfg_we,
    input cfg_addr_t cfg_addr,
    input logic      req_valid,
    input logic      req_write,
    input sector_t   req_sector,
    input sector_t   xlat_sector,
    input logic      xlat_encrypt,
    input logic      irq,
    input slot_idx_t irq_slot,
    input slot_cfg_t slots [NUM_SLOTS],
    input sector_t   win_lo,
    input sector_t   win_hi
);

    logic none_active;
    logic clr_wr;
    logic wr_req;

    always_comb begin
        none_active = 1'b1;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slots[i].span != '0) none_active = 1'b0;
        end
        clr_wr = cfg_we && (cfg_addr == IRQ_CLR_ADDR);
        wr_req = req_valid && req_write;
    end

    assert_passthru_idle_R2: assert property (@(posedge clk) disable iff (rst)
        none_active |-> (xlat_sector == req_sector));

    assert_encrypt_all_R5: assert property (@(posedge clk) disable iff (rst)
        (win_lo >= win_hi) |-> xlat_encrypt);

    assert_read_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!irq && !wr_req) |=> !irq);

    assert_write_hit_irq_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && (xlat_sector != req_sector)) |=> irq);

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_wr) |=> (irq && $stable(irq_slot)));

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && clr_wr && !wr_req) |=> !irq);

endmodule

bind sector_remap_unit sremap_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_sector   (req_sector),
    .xlat_sector  (xlat_sector),
    .xlat_encrypt (xlat_encrypt),
    .irq          (irq),
    .irq_slot     (irq_slot),
    .slots        (slot_cfg),
    .win_lo       (win_lo),
    .win_hi       (win_hi)
);

// File: tb/sector_remap_unit_test.sv
`timescale 1ns/1ps
module sector_remap_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_sector = '0;
    logic [31:0] xlat_sector;
    logic        xlat_encrypt;
    logic        irq;
    logic [1:0]  irq_slot;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sector_remap_unit uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_sector(req_sector), .xlat_sector(xlat_sector),
        .xlat_encrypt(xlat_encrypt), .irq(irq), .irq_slot(irq_slot)
    );

    localparam int NV = 13;
    localparam logic [31:0] V_SECT [NV] = '{100, 107, 108, 99, 203, 204, 211, 212, 300, 1000, 1999, 2000, 999};
    localparam logic [31:0] V_XLAT [NV] = '{5000, 5007, 108, 99, 6003, 7002, 7009, 212, 300, 1000, 1999, 2000, 999};
    localparam logic        V_ENC  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [31:0] s, input logic wr,
                          output logic [31:0] xs, output logic en);
        @(negedge clk);
        req_valid = 1'b1; req_sector = s; req_write = wr;
        #1;
        xs = xlat_sector; en = xlat_encrypt;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] xs;
        logic en;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // Reset state: no slot active, window invalid
        access(32'd123, 1'b0, xs, en);
        chk("R9 reset irq", {31'd0, irq}, 0);
        chk("R2 reset passthru", xs, 123);
        chk("R5 reset encrypt all", {31'd0, en}, 1);

        // Setup through the register map (R9)
        cfg_write(0, 100);  cfg_write(1, 8);  cfg_write(2, 5000);
        cfg_write(3, 200);  cfg_write(4, 4);  cfg_write(5, 6000);
        cfg_write(6, 202);  cfg_write(7, 10); cfg_write(8, 7000);
        cfg_write(9, 300);  cfg_write(10, 0); cfg_write(11, 9000);
        cfg_write(12, 1000); cfg_write(13, 2000);

        for (int i = 0; i < NV; i++) begin
            access(V_SECT[i], 1'b0, xs, en);
            chk("R1/R2/R3/R9 translate", xs, V_XLAT[i]);
            chk("R4 encrypt flag", {31'd0, en}, {31'd0, V_ENC[i]});
        end
        chk("R7 reads raise no irq", {31'd0, irq}, 0);

        // Write hit in overlap-free part of slot 2
        access(32'd205, 1'b1, xs, en);
        chk("R6 irq set", {31'd0, irq}, 1);
        chk("R6 irq slot", {30'd0, irq_slot}, 2);
        access(32'd100, 1'b1, xs, en);
        chk("R8 irq slot held", {30'd0, irq_slot}, 2);
        cfg_write(14, 0);
        chk("R8 irq cleared", {31'd0, irq}, 0);

        access(32'd300, 1'b1, xs, en);
        chk("R2 zero-length slot no irq", {31'd0, irq}, 0);
        access(32'd150, 1'b1, xs, en);
        chk("R2 miss write no irq", {31'd0, irq}, 0);
        access(32'd203, 1'b1, xs, en);
        chk("R3 overlap write slot", {30'd0, irq_slot}, 1);
        cfg_write(14, 0);
        access(32'd107, 1'b1, xs, en);
        chk("R6 slot0 irq", {31'd0, irq}, 1);
        chk("R6 slot0 index", {30'd0, irq_slot}, 0);
        cfg_write(14, 0);

        // Cipher window corners
        cfg_write(12, 5000); cfg_write(13, 5000);
        access(32'd10, 1'b0, xs, en);
        chk("R5 empty window encrypt", {31'd0, en}, 1);
        cfg_write(12, 6000);
        access(32'd5500, 1'b0, xs, en);
        chk("R5 inverted window encrypt", {31'd0, en}, 1);
        cfg_write(12, 4000);
        access(32'd10, 1'b0, xs, en);
        chk("R4 below window", {31'd0, en}, 0);
        access(32'd4000, 1'b0, xs, en);
        chk("R4 window low edge", {31'd0, en}, 1);

        // Reset clears the slots
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        access(32'd100, 1'b0, xs, en);
        chk("R9 reset clears slot", xs, 100);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule